// File: doc/BRIEF.md
# CAN Controller Interrupt and Error Flag Unit

This unit sits beside the protocol engine and message mailboxes of a CAN controller. It gathers two kinds of events and turns them into two interrupt lines. The first kind is per-mailbox completion pulses. The second kind is error-confinement state changes, which the unit derives itself from the transmit and receive error counter values. It also keeps sticky flags for single bus-error pulses (form, bit, stuck-dominant, CRC, stuff and acknowledge).

Software reaches the unit through a small register port:

| Address | Register |
|---|---|
| 0 | error status |
| 1 | global mask |
| 2 | mailbox mask |
| 3 | mailbox routing level |
| 4 | flag word for line 0 |
| 5 | flag word for line 1 |

Mailbox events go to line 0 or line 1 according to a per-mailbox level bit. Error-state events go to one line chosen by a single routing bit. Each flag word reports a mailbox-pending summary bit and the number of the highest pending mailbox on its line.

Top module: `can_irq_unit`

## Requirements
- R1: After reset every register reads 0 and both interrupt lines are low.
- R2: A pulse on `bus_err[5]`..`bus_err[0]` (form, bit, stuck-dominant, CRC, stuff, ack) sets error-status bits 24..19 respectively. Each bit stays set until a 1 is written to it.
- R3: When the larger error counter rises from 96 or below to above 96, error-status bit 16 (warning) is set. When it rises from 127 or below to above 127, bit 17 (passive) is set. When the transmit counter rises from 255 or below to above 255, bit 18 (bus-off) is set. Each new crossing also sets the matching flag bit: 8 for warning, 9 for passive, 10 for bus-off. A counter that stays above a limit, or falls below it, causes no new event. Writing 1 to a status bit clears that bit.
- R4: Error-state flag bits go to the line 1 flag word when global-mask bit 2 is 1. They go to the line 0 flag word when that bit is 0.
- R5: A mailbox event is latched only when that mailbox's bit in the mailbox mask is set. The mailbox's level bit routes it to line 1 when 1 and to line 0 when 0.
- R6: Bit 15 of a flag word is 1 while any mailbox routed to that line is pending. Bits 4:0 of the word then hold the highest pending mailbox number on that line.
- R7: Interrupt line n is high, one cycle after its inputs, when line-enable bit n of the global mask is set and either of these holds: flag bit 15 of word n is set, or a flag bit among 10:8 of word n is set with the same bit set in the global mask.
- R8: Writing a flag word clears each error-state flag bit written as 1. A 1 in bit 15 clears every pending mailbox routed to that line, so writing all ones clears the whole word.
- R9: An event arriving in the same cycle as a write that clears its flag leaves the flag set.
- R10: `reg_rdata` shows the register selected by `reg_addr` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mbx_evt | input | NMBX | Per-mailbox completion pulses |
| tec | input | CW | Transmit error counter value |
| rec | input | CW | Receive error counter value |
| bus_err | input | 6 | Bus-error pulses: form, bit, stuck, CRC, stuff, ack (bit 5 down to 0) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |

## Verification
The bench goes after these corner cases:

- **Masked mailbox in a burst with enabled ones.** A design that skips the mask would report mailbox 0 or raise a flag for it.
- **Highest-number pick among several pending mailboxes.** A lowest-first encoder would report 4 instead of 5.
- **Line enable cleared while a mailbox is pending, and error flags masked in the global mask.** A missing gate leaves the line asserted.
- **Error counter sitting exactly at 96, and a counter staying above a limit after its status bit is cleared.** A level-triggered or off-by-one comparator would re-set warning.
- **A clear write landing in the same cycle as a new event.** A design that lets the write win loses the event.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int NBERR  = 6;

  typedef enum logic [ADDR_W-1:0] {
    RA_ESTAT = 3'd0,
    RA_GMASK = 3'd1,
    RA_MMASK = 3'd2,
    RA_MLVL  = 3'd3,
    RA_FLAG0 = 3'd4,
    RA_FLAG1 = 3'd5
  } reg_addr_e;

  // error-status field positions
  localparam int ES_WARN  = 16;
  localparam int ES_PASS  = 17;
  localparam int ES_BOFF  = 18;
  localparam int ES_BE_LO = 19;
  localparam int ES_TOP   = 24;

  // flag word positions
  localparam int FL_SYS_LO = 8;
  localparam int FL_SYS_HI = 10;
  localparam int FL_MBX    = 15;

  // global mask positions
  localparam int GM_EN0  = 0;
  localparam int GM_EN1  = 1;
  localparam int GM_SYS1 = 2;

  typedef struct packed {
    logic boff;
    logic pass;
    logic warn;
  } sys_evt_t;

endpackage

// File: rtl/can_irq_err_track.sv
module can_irq_err_track
  import can_irq_pkg::*;
#(
  parameter int CW       = 9,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 127,
  parameter int BOFF_LIM = 255
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CW-1:0]            tec,
  input  logic [CW-1:0]            rec,
  input  logic [NBERR-1:0]         bus_err,
  input  logic                     clr_we,
  input  logic [ES_TOP-ES_WARN:0]  clr_bits,
  output logic [ES_TOP-ES_WARN:0]  est,
  output sys_evt_t                 sys_evt
);

  localparam int EW = ES_TOP - ES_WARN + 1;

  logic [CW-1:0] cnt_max;
  sys_evt_t      cond, cond_q;
  logic [EW-1:0] est_q, set_v, clr_v;

  assign cnt_max = (tec > rec) ? tec : rec;

  always_comb begin
    cond.warn = cnt_max > CW'(WARN_LIM);
    cond.pass = cnt_max > CW'(PASS_LIM);
    cond.boff = tec > CW'(BOFF_LIM);
  end

  assign sys_evt = cond & ~cond_q;
  assign set_v   = {bus_err, sys_evt.boff, sys_evt.pass, sys_evt.warn};
  assign clr_v   = clr_we ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= '0;
      est_q  <= '0;
    end else begin
      cond_q <= cond;
      est_q  <= (est_q & ~clr_v) | set_v;
    end
  end

  assign est = est_q;

endmodule

// File: rtl/can_irq_mbx_route.sv
module can_irq_mbx_route #(
  parameter int NMBX = 32,
  parameter int IW   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NMBX-1:0]      mbx_evt,
  input  logic [NMBX-1:0]      mmask,
  input  logic [NMBX-1:0]      mlvl,
  input  logic [1:0]           clr_line,
  output logic [NMBX-1:0]      pend,
  output logic [1:0]           hit,
  output logic [1:0][IW-1:0]   idx
);

  logic [NMBX-1:0] pend_q, clr_mask;

  assign clr_mask = ({NMBX{clr_line[1]}} & mlvl) | ({NMBX{clr_line[0]}} & ~mlvl);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | (mbx_evt & mmask);
  end

  assign pend = pend_q;

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [NMBX-1:0] lp;
    assign lp = (l == 1) ? (pend_q & mlvl) : (pend_q & ~mlvl);
    assign hit[l] = |lp;
    always_comb begin
      idx[l] = '0;
      for (int i = 0; i < NMBX; i++)
        if (lp[i]) idx[l] = IW'(i);
    end
  end

endmodule

// File: rtl/can_irq_line.sv
module can_irq_line
  import can_irq_pkg::*;
#(
  parameter int LINE = 0,
  parameter int IW   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  sys_evt_t            sys_evt,
  input  logic                sys_sel,
  input  logic [2:0]          sys_en,
  input  logic                line_en,
  input  logic                mbx_hit,
  input  logic [IW-1:0]       mbx_idx,
  input  logic                clr_we,
  input  logic [2:0]          clr_sys,
  output logic [DATA_W-1:0]   flag,
  output logic                irq
);

  logic [2:0] sysf_q, set_v, clr_v;
  logic       irq_q;

  assign set_v = (sys_sel == 1'(LINE)) ? sys_evt : 3'b000;
  assign clr_v = clr_we ? clr_sys : 3'b000;

  always_ff @(posedge clk) begin
    if (rst) begin
      sysf_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      sysf_q <= (sysf_q & ~clr_v) | set_v;
      irq_q  <= line_en & (mbx_hit | (|(sysf_q & sys_en)));
    end
  end

  always_comb begin
    flag = '0;
    flag[FL_SYS_HI:FL_SYS_LO] = sysf_q;
    flag[FL_MBX] = mbx_hit;
    if (mbx_hit) flag[IW-1:0] = mbx_idx;
  end

  assign irq = irq_q;

endmodule

// File: rtl/can_irq_unit.sv
module can_irq_unit
  import can_irq_pkg::*;
#(
  parameter int NMBX = 32,
  parameter int CW   = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NMBX-1:0]   mbx_evt,
  input  logic [CW-1:0]     tec,
  input  logic [CW-1:0]     rec,
  input  logic [5:0]        bus_err,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq0,
  output logic              irq1
);

  localparam int IW = (NMBX > 1) ? $clog2(NMBX) : 1;
  localparam int EW = ES_TOP - ES_WARN + 1;

  logic [2:0]        gm_line_q;   // en0, en1, sys-to-line1
  logic [2:0]        gm_sys_q;    // enables for flag bits 10:8
  logic [NMBX-1:0]   mmask_q, mlvl_q, pend_w;
  logic [EW-1:0]     est_w;
  sys_evt_t          sys_evt_w;
  logic [1:0]        hit_w, irq_w, flag_we;
  logic [1:0][IW-1:0] idx_w;
  logic [1:0][31:0]  flag_w;
  logic [31:0]       estat_w, rd_mux;
  logic              we_estat;

  assign we_estat   = reg_we && (reg_addr == RA_ESTAT);
  assign flag_we[0] = reg_we && (reg_addr == RA_FLAG0);
  assign flag_we[1] = reg_we && (reg_addr == RA_FLAG1);

  always_ff @(posedge clk) begin
    if (rst) begin
      gm_line_q <= '0;
      gm_sys_q  <= '0;
      mmask_q   <= '0;
      mlvl_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_GMASK: begin
          gm_line_q <= reg_wdata[2:0];
          gm_sys_q  <= reg_wdata[FL_SYS_HI:FL_SYS_LO];
        end
        RA_MMASK: mmask_q <= reg_wdata[NMBX-1:0];
        RA_MLVL:  mlvl_q  <= reg_wdata[NMBX-1:0];
        default: ;
      endcase
    end
  end

  can_irq_err_track #(.CW(CW)) u_err (
    .clk      (clk),
    .rst      (rst),
    .tec      (tec),
    .rec      (rec),
    .bus_err  (bus_err),
    .clr_we   (we_estat),
    .clr_bits (reg_wdata[ES_TOP:ES_WARN]),
    .est      (est_w),
    .sys_evt  (sys_evt_w)
  );

  can_irq_mbx_route #(.NMBX(NMBX), .IW(IW)) u_mbx (
    .clk      (clk),
    .rst      (rst),
    .mbx_evt  (mbx_evt),
    .mmask    (mmask_q),
    .mlvl     (mlvl_q),
    .clr_line (flag_we & {2{reg_wdata[FL_MBX]}}),
    .pend     (pend_w),
    .hit      (hit_w),
    .idx      (idx_w)
  );

  for (genvar l = 0; l < 2; l++) begin : g_ln
    can_irq_line #(.LINE(l), .IW(IW)) u_line (
      .clk     (clk),
      .rst     (rst),
      .sys_evt (sys_evt_w),
      .sys_sel (gm_line_q[GM_SYS1]),
      .sys_en  (gm_sys_q),
      .line_en (gm_line_q[l]),
      .mbx_hit (hit_w[l]),
      .mbx_idx (idx_w[l]),
      .clr_we  (flag_we[l]),
      .clr_sys (reg_wdata[FL_SYS_HI:FL_SYS_LO]),
      .flag    (flag_w[l]),
      .irq     (irq_w[l])
    );
  end

  always_comb begin
    estat_w = '0;
    estat_w[ES_TOP:ES_WARN] = est_w;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RA_ESTAT: rd_mux = estat_w;
      RA_GMASK: begin
        rd_mux[2:0] = gm_line_q;
        rd_mux[FL_SYS_HI:FL_SYS_LO] = gm_sys_q;
      end
      RA_MMASK: rd_mux[NMBX-1:0] = mmask_q;
      RA_MLVL:  rd_mux[NMBX-1:0] = mlvl_q;
      RA_FLAG0: rd_mux = flag_w[0];
      RA_FLAG1: rd_mux = flag_w[1];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  assign irq0 = irq_w[0];
  assign irq1 = irq_w[1];

endmodule

// File: rtl/can_irq_unit_chk.sv
module can_irq_unit_chk #(
  parameter int NMBX = 32,
  parameter int CW   = 9
) (
  input logic            clk,
  input logic            rst,
  input logic [NMBX-1:0] mbx_evt,
  input logic [CW-1:0]   tec,
  input logic [5:0]      bus_err,
  input logic            irq0,
  input logic            irq1,
  input logic [1:0]      line_en,
  input logic [NMBX-1:0] mmask,
  input logic [NMBX-1:0] mlvl,
  input logic [NMBX-1:0] pend,
  input logic [31:0]     flag0,
  input logic [31:0]     estat
);

  localparam int IW = (NMBX > 1) ? $clog2(NMBX) : 1;

  // R7: a disabled line stays low on the next cycle
  assert_line0_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !line_en[0] |=> !irq0);
  assert_line1_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !line_en[1] |=> !irq1);

  // R5: no mailbox becomes pending without an unmasked event
  assert_mask_respected_R5: assert property (@(posedge clk) disable iff (rst)
    ((pend & ~$past(pend) & ~($past(mbx_evt) & $past(mmask))) == '0));

  // R6: reported number on line 0 names a pending line-0 mailbox
  assert_index_pending_R6: assert property (@(posedge clk) disable iff (rst)
    flag0[15] |-> (pend[flag0[IW-1:0]] && !mlvl[flag0[IW-1:0]]));

  // R2: every bus-error pulse is visible in status on the next cycle
  assert_buserr_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    (|bus_err) |=> ((estat[24:19] & $past(bus_err)) == $past(bus_err)));

  // R3: crossing the bus-off limit sets the bus-off status bit
  assert_busoff_set_R3: assert property (@(posedge clk) disable iff (rst)
    (tec > CW'(255)) && !$past(tec > CW'(255)) |=> estat[18]);

endmodule

bind can_irq_unit can_irq_unit_chk #(.NMBX(NMBX), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .mbx_evt (mbx_evt),
  .tec     (tec),
  .bus_err (bus_err),
  .irq0    (irq0),
  .irq1    (irq1),
  .line_en (gm_line_q[1:0]),
  .mmask   (mmask_q),
  .mlvl    (mlvl_q),
  .pend    (pend_w),
  .flag0   (flag_w[0]),
  .estat   (estat_w)
);

// File: tb/can_irq_unit_bench.sv
module can_irq_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NMBX = 32;
  localparam int CW   = 9;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NMBX-1:0] mbx_evt = '0;
  logic [CW-1:0]   tec = '0, rec = '0;
  logic [5:0]      bus_err = '0;
  logic            reg_we = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            irq0, irq1;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_req = 1'b0, rd_req_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_irq_unit u_can_irq_unit (
    .clk(clk), .rst(rst), .mbx_evt(mbx_evt), .tec(tec), .rec(rec),
    .bus_err(bus_err), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq0(irq0), .irq1(irq1)
  );

  always @(posedge clk) rd_req_d <= rd_req;

  // monitor: pops expected read values as results appear
  always @(negedge clk) begin
    if (rd_req_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s: got %08h expected %08h", t, reg_rdata, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] e, string t);
    @(negedge clk);
    reg_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pulse_mbx(logic [NMBX-1:0] v);
    @(negedge clk); mbx_evt = v;
    @(negedge clk); mbx_evt = '0;
  endtask

  task automatic chk_irq(logic e0, logic e1, string t);
    total++;
    if (irq0 !== e0 || irq1 !== e1) begin
      bad++;
      $display("FAIL %s: irq got %b%b expected %b%b", t, irq1, irq0, e1, e0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk_irq(1'b0, 1'b0, "R1 irq reset");
    for (int a = 0; a < 6; a++) rd(3'(a), 32'h0, "R1 reg reset");

    // R5 R6 R7 mailbox routing
    wr(3'd1, 32'h0000_0701);
    wr(3'd2, 32'h0000_00F0);
    wr(3'd3, 32'h0000_00C0);
    pulse_mbx(32'h0000_0031);
    idle(2);
    rd(3'd4, 32'h0000_8005, "R6 R5 highest unmasked on line0");
    rd(3'd5, 32'h0000_0000, "R5 line1 untouched");
    chk_irq(1'b1, 1'b0, "R7 line0 mailbox");
    pulse_mbx(32'h0000_0080);
    idle(2);
    rd(3'd5, 32'h0000_8007, "R5 level routes to line1");
    chk_irq(1'b1, 1'b0, "R7 line1 disabled");
    wr(3'd1, 32'h0000_0703);
    idle(2);
    chk_irq(1'b1, 1'b1, "R7 line1 enabled");

    // R8 clear pending mailboxes on line0 only
    wr(3'd4, 32'h0000_8000);
    idle(2);
    rd(3'd4, 32'h0000_0000, "R8 line0 cleared");
    rd(3'd5, 32'h0000_8007, "R8 line1 kept");
    chk_irq(1'b0, 1'b1, "R8 irq0 drops");

    // R3 R4 error state
    tec = 9'd100;
    idle(2);
    rd(3'd0, 32'h0001_0000, "R3 warning");
    rd(3'd4, 32'h0000_0100, "R3 warning flag");
    chk_irq(1'b1, 1'b1, "R7 sys flag line0");
    tec = 9'd130;
    idle(2);
    rd(3'd0, 32'h0003_0000, "R3 passive");
    rd(3'd4, 32'h0000_0300, "R3 passive flag");
    wr(3'd1, 32'h0000_0707);
    tec = 9'd300;
    idle(2);
    rd(3'd0, 32'h0007_0000, "R3 busoff");
    rd(3'd5, 32'h0000_8407, "R4 busoff to line1");
    rd(3'd4, 32'h0000_0300, "R4 line0 unchanged");

    // R7 system mask
    wr(3'd1, 32'h0000_0001);
    idle(2);
    chk_irq(1'b0, 1'b0, "R7 sys masked");

    // R3 W1C, R8 full clear
    wr(3'd0, 32'h0001_0000);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    idle(1);
    rd(3'd0, 32'h0006_0000, "R3 w1c no re-set");
    rd(3'd4, 32'h0000_0000, "R8 line0 all clear");
    rd(3'd5, 32'h0000_0000, "R8 line1 all clear");

    // R2 bus errors
    @(negedge clk); bus_err = 6'b100001;
    @(negedge clk); bus_err = 6'b000000;
    rd(3'd0, 32'h010E_0000, "R2 form ack");
    @(negedge clk); bus_err = 6'b011110;
    @(negedge clk); bus_err = 6'b000000;
    rd(3'd0, 32'h01FE_0000, "R2 all bus errors");
    wr(3'd0, 32'hFFFF_FFFF);
    idle(1);
    rd(3'd0, 32'h0000_0000, "R2 cleared");

    // R9 set wins over clear
    @(negedge clk);
    bus_err = 6'b100000; mbx_evt = 32'h0000_0010;
    reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0100_0000;
    @(negedge clk);
    bus_err = '0; mbx_evt = '0; reg_we = 1'b0;
    rd(3'd0, 32'h0100_0000, "R9 status set wins");
    @(negedge clk);
    mbx_evt = 32'h0000_0010;
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h0000_8000;
    @(negedge clk);
    mbx_evt = '0; reg_we = 1'b0;
    idle(1);
    rd(3'd4, 32'h0000_8004, "R9 mailbox set wins");
    chk_irq(1'b1, 1'b0, "R7 irq0 after set-wins");

    // R3 receive counter boundary
    tec = 9'd0; rec = 9'd96;
    idle(2);
    rd(3'd0, 32'h0100_0000, "R3 at 96 no warning");
    rec = 9'd97;
    idle(2);
    rd(3'd0, 32'h0101_0000, "R3 rec warning");
    rd(3'd4, 32'h0000_8104, "R3 R4 rec warning flag line0");
    rd(3'd1, 32'h0000_0001, "R10 gmask readback");

    idle(3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule